// File: doc/BRIEF.md
# Multi-Mode Phase Counting Channel

This block is one up/down counter channel fed by two external phase inputs, A and B. Both inputs pass through a synchroniser. A decoder then turns their edges into count steps according to a mode code that software selects at run time. Three decodings are supported: quadrature with a step on all four edges, pulse counting with B as the direction input, and quadrature with a step on the edges of B only. The count runs between zero and a programmable ceiling. An up step taken while the count sits at the ceiling clears it to zero, and a down step taken at zero reloads the ceiling. A sticky flag records whether the most recent step went up or down.

Software reaches the channel through a small register port with one write path and one read path. The read data is registered. The control register holds the enable bit. The mode register holds the decode code. The ceiling and count registers can be read and written. The status register is read-only and carries the direction flag. The live count and the direction flag are also driven on dedicated output ports for neighbouring logic.

Top module: `pcc_channel`

## Requirements
- R1: After reset the count is 0, the direction flag is 0, the enable bit is 0, the mode code is 4 and the ceiling is all ones.
- R2: With mode code 4, each edge of A or B steps the count once. The step is up when A leads B (state {A,B} going 00, 10, 11, 01) and down in the reverse order.
- R3: In the quadrature modes (codes 4 and 7), a sample in which A and B both change leaves the count unchanged.
- R4: With mode code 5, only a rising edge of A steps the count. B high at that moment means up and B low means down. Falling edges of A and all edges of B do nothing.
- R5: With mode code 7, each edge of B steps the count, with the same direction rule as R2. Edges of A alone do nothing.
- R6: Status register (address 4) bit 7 and output up_flag_o are 1 after an up step and 0 after a down step.
- R7: An up step taken while the count equals the ceiling sets the count to 0.
- R8: A down step taken while the count is 0 loads the ceiling value into the count.
- R9: While control register (address 0) bit 0 is 0, no step changes the count.
- R10: Any mode code other than 4, 5 or 7 holds the count.
- R11: A software write to the count register (address 3) takes priority over a step in the same cycle, and that step is dropped.
- R12: A change on a phase input first shows in count_o at the third rising clock edge after the change.
- R13: The read data appears one cycle after the read address. Mode (address 1) reads back only its low 4 bits. The ceiling is at address 2. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Asynchronous phase A input |
| phase_b | input | 1 | Asynchronous phase B input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | CNT_W (16) | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | CNT_W (16) | Registered read data |
| count_o | output | CNT_W (16) | Current count |
| up_flag_o | output | 1 | Direction of the last step (1 = up) |

## Verification
The bench builds the channel with its defaults: a 16-bit count, a 3-bit register address and a two-stage synchroniser. With the ceiling at its reset value of all ones, a down step from zero reaches the top of the range in one step. Writing a small ceiling such as 3 makes the clear-on-ceiling boundary reachable within a few edges. Because the synchroniser depth stays at two, the latency check can pin the exact edge at which a phase change first moves the count.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam logic [3:0] PCC_MODE_QUAD4  = 4'd4;
  localparam logic [3:0] PCC_MODE_PULSE  = 4'd5;
  localparam logic [3:0] PCC_MODE_QUAD2B = 4'd7;

  localparam int PCC_REG_CTRL  = 0;
  localparam int PCC_REG_MODE  = 1;
  localparam int PCC_REG_CEIL  = 2;
  localparam int PCC_REG_COUNT = 3;
  localparam int PCC_REG_STAT  = 4;

  localparam int PCC_DIR_BIT   = 7;
  localparam int PCC_MODE_W    = 4;
endpackage

// File: rtl/pcc_sync.sv
module pcc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcc_decode.sv
module pcc_decode
  import pcc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PCC_MODE_W-1:0] mode,
  input  logic                  a,
  input  logic                  b,
  output logic                  step,
  output logic                  up
);
  logic a_prev, b_prev;
  logic a_chg, b_chg, quad_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a;
      b_prev <= b;
    end
  end

  assign a_chg   = a ^ a_prev;
  assign b_chg   = b ^ b_prev;
  // For a single-input change, A leading B gives new A differing from old B.
  assign quad_up = a ^ b_prev;

  always_comb begin
    step = 1'b0;
    up   = 1'b0;
    case (mode)
      PCC_MODE_QUAD4: begin
        step = a_chg ^ b_chg;
        up   = quad_up;
      end
      PCC_MODE_PULSE: begin
        step = a & ~a_prev;
        up   = b;
      end
      PCC_MODE_QUAD2B: begin
        step = b_chg & ~a_chg;
        up   = quad_up;
      end
      default: begin
        step = 1'b0;
        up   = 1'b0;
      end
    endcase
  end

  p_quad_double_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode == PCC_MODE_QUAD4 || mode == PCC_MODE_QUAD2B) && (a != a_prev) && (b != b_prev)) |-> !step);

  p_pulse_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PCC_MODE_PULSE && step) |-> (a && !a_prev));

  p_x2_ignore_a_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == PCC_MODE_QUAD2B && (a != a_prev)) |-> !step);

  p_unlisted_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mode != PCC_MODE_QUAD4 && mode != PCC_MODE_PULSE && mode != PCC_MODE_QUAD2B) |-> !step);
endmodule

// File: rtl/pcc_core.sv
module pcc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             step,
  input  logic             up,
  input  logic [CNT_W-1:0] ceiling,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_val,
  output logic [CNT_W-1:0] count,
  output logic             dir_up
);
  logic take;
  assign take = enable & step & ~sw_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b0;
    end else if (sw_wr) begin
      count <= sw_val;
    end else if (take) begin
      dir_up <= up;
      if (up) count <= (count == ceiling) ? '0 : count + 1'b1;
      else    count <= (count == '0) ? ceiling : count - 1'b1;
    end
  end

  p_dir_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && step && !sw_wr) |=> (dir_up == $past(up)));

  p_clear_at_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && step && up && !sw_wr && count == ceiling) |=> (count == '0));

  p_wrap_from_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && step && !up && !sw_wr && count == '0) |=> (count == $past(ceiling)));

  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !sw_wr) |=> $stable(count));

  p_sw_wins_r11: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (count == $past(sw_val)));
endmodule

// File: rtl/pcc_channel.sv
module pcc_channel
  import pcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              up_flag_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(PCC_REG_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(PCC_REG_MODE);
  localparam logic [ADDR_W-1:0] A_CEIL  = ADDR_W'(PCC_REG_CEIL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(PCC_REG_COUNT);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(PCC_REG_STAT);

  logic                  en_q;
  logic [PCC_MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]      ceil_q;
  logic [1:0]            ph_sync;
  logic                  dec_step, dec_up;
  logic                  cnt_wr;
  logic [CNT_W-1:0]      count_w;
  logic                  dir_w;
  logic [CNT_W-1:0]      stat_w;
  logic [CNT_W-1:0]      rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= PCC_MODE_QUAD4;
      ceil_q <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) en_q   <= wr_data[0];
      if (wr_addr == A_MODE) mode_q <= wr_data[PCC_MODE_W-1:0];
      if (wr_addr == A_CEIL) ceil_q <= wr_data;
    end
  end

  assign cnt_wr = wr_en & (wr_addr == A_COUNT);

  pcc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({phase_a, phase_b}),
    .dout(ph_sync)
  );

  pcc_decode u_dec (
    .clk (clk),
    .rst (rst),
    .mode(mode_q),
    .a   (ph_sync[1]),
    .b   (ph_sync[0]),
    .step(dec_step),
    .up  (dec_up)
  );

  pcc_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .enable (en_q),
    .step   (dec_step),
    .up     (dec_up),
    .ceiling(ceil_q),
    .sw_wr  (cnt_wr),
    .sw_val (wr_data),
    .count  (count_w),
    .dir_up (dir_w)
  );

  always_comb begin
    stat_w = '0;
    stat_w[PCC_DIR_BIT] = dir_w;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_mux = {{(CNT_W-1){1'b0}}, en_q};
      A_MODE:  rd_mux = {{(CNT_W-PCC_MODE_W){1'b0}}, mode_q};
      A_CEIL:  rd_mux = ceil_q;
      A_COUNT: rd_mux = count_w;
      A_STAT:  rd_mux = stat_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign count_o   = count_w;
  assign up_flag_o = dir_w;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !up_flag_o && mode_q == PCC_MODE_QUAD4 && ceil_q == '1));

  p_read_latency_r13: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CEIL && !(wr_en && wr_addr == A_CEIL)) |=> (rd_data == ceil_q));
endmodule

// File: tb/sim_pcc_channel.sv
module sim_pcc_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_a = 1'b0, phase_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, count_o;
  logic        up_flag_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  pcc_channel u0 (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_o(count_o), .up_flag_o(up_flag_o)
  );

  // Four-edge quadrature walk: {a, b, expected count}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
    {2'b01, 16'h0003}, {2'b11, 16'h0002}, {2'b10, 16'h0001}, {2'b00, 16'h0000},
    {2'b01, 16'hFFFF}, {2'b00, 16'h0000}, {2'b11, 16'h0000}, {2'b10, 16'hFFFF}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    tick(1);
    d = rd_data;
  endtask

  task automatic ab(input logic a, input logic b);
    phase_a = a; phase_b = b;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 count", count_o, 16'h0000);
    check("R1 dir", {15'b0, up_flag_o}, 16'h0000);
    rd(3'd1, rv); check("R1 mode", rv, 16'h0004);
    rd(3'd2, rv); check("R1 ceiling", rv, 16'hFFFF);
    rd(3'd0, rv); check("R1 enable", rv, 16'h0000);

    wr(3'd0, 16'h0001);
    // R2 R3 R7 R8 table walk in mode 4
    for (int i = 0; i < NV; i++) begin
      ab(VEC[i][17], VEC[i][16]);
      check($sformatf("R2/R3/R7/R8 vec%0d", i), count_o, VEC[i][15:0]);
    end

    // R12 synchroniser latency
    ab(1'b0, 1'b0);
    wr(3'd3, 16'h0010);
    phase_a = 1'b1;
    tick(2);
    check("R12 before third edge", count_o, 16'h0010);
    tick(1);
    check("R12 at third edge", count_o, 16'h0011);
    tick(2);

    // R6 direction flag through status
    rd(3'd4, rv); check("R6 up status", rv, 16'h0080);
    ab(1'b0, 1'b0);
    rd(3'd4, rv); check("R6 down status", rv, 16'h0000);
    check("R6 flag port", {15'b0, up_flag_o}, 16'h0000);

    // R9 disabled holds
    wr(3'd0, 16'h0000);
    ab(1'b1, 1'b0);
    ab(1'b1, 1'b1);
    check("R9 disabled hold", count_o, 16'h0010);
    ab(1'b0, 1'b0);
    wr(3'd0, 16'h0001);

    // R10 unlisted modes hold
    wr(3'd1, 16'h0006);
    ab(1'b1, 1'b0);
    ab(1'b0, 1'b0);
    check("R10 mode 6 hold", count_o, 16'h0010);
    wr(3'd1, 16'h0009);
    ab(1'b0, 1'b1);
    ab(1'b0, 1'b0);
    check("R10 mode 9 hold", count_o, 16'h0010);

    // R4 pulse and direction
    wr(3'd1, 16'h0005);
    ab(1'b0, 1'b1);
    check("R4 B edge ignored", count_o, 16'h0010);
    ab(1'b1, 1'b1);
    check("R4 rise with B high", count_o, 16'h0011);
    ab(1'b0, 1'b1);
    check("R4 fall ignored", count_o, 16'h0011);
    ab(1'b0, 1'b0);
    ab(1'b1, 1'b0);
    check("R4 rise with B low", count_o, 16'h0010);
    ab(1'b0, 1'b0);

    // R5 two-edge on B
    wr(3'd1, 16'h0007);
    ab(1'b1, 1'b0);
    check("R5 A edge ignored", count_o, 16'h0010);
    ab(1'b1, 1'b1);
    check("R5 B rise counts up", count_o, 16'h0011);
    ab(1'b1, 1'b0);
    check("R5 B fall counts down", count_o, 16'h0010);
    ab(1'b0, 1'b1);
    check("R3 double change in mode 7", count_o, 16'h0010);
    ab(1'b0, 1'b0);

    // R7 R8 with small ceiling
    wr(3'd1, 16'h0004);
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0003);
    ab(1'b1, 1'b0);
    check("R7 clear at ceiling", count_o, 16'h0000);
    ab(1'b0, 1'b0);
    check("R8 reload ceiling", count_o, 16'h0003);

    // R11 software write wins over coincident step
    wr(3'd2, 16'hFFFF);
    phase_a = 1'b1;
    tick(2);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1234;
    tick(1);
    wr_en = 1'b0;
    tick(3);
    check("R11 write priority", count_o, 16'h1234);

    // R13 read port
    wr(3'd1, 16'hFFF5);
    rd(3'd1, rv); check("R13 mode low bits", rv, 16'h0005);
    rd(3'd7, rv); check("R13 unmapped", rv, 16'h0000);
    rd(3'd3, rv); check("R13 count read", rv, 16'h1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule